// File: doc/BRIEF.md
# Serial Converter Frame Master

This block is the host side of a four-wire link to a four-input, 8-bit serial analog-to-digital converter. A single start pulse hands it a list of one to four channels and a half-period divider. It drops chip select and runs one 16-clock conversion per list entry back to back under that one chip select. During each conversion it shifts out a control word that names the next channel and shifts in the 8-bit result. It then raises chip select, which lets the converter power down.

Channel selection inside the converter lags by one conversion. The address sent during a conversion only takes effect in the conversion that follows. The block remembers the address it sent last and tags each result with the channel it really came from. The first conversion after reset always reports input 1. Within a frame, conversion i sends list entry i+1, and the last conversion sends entry 0. A frame that repeats the previous list therefore returns exactly that list. A divider that would put the serial clock outside 0.8 to 3.2 MHz is refused.

Top module: `adcm_frame_master`

## Requirements
- R1: After reset, chip select and the serial clock are high, and busy, reject, result valid and the data line are all low.
- R2: Each frame holds chip select low for exactly 16 times the number of conversions of rising serial clock edges. The serial clock is high both when chip select falls and when it rises again.
- R3: Each serial clock half period lasts exactly `half_div` system clocks. The first falling edge comes `half_div` system clocks after chip select falls.
- R4: During each conversion, the control word goes out MSB first on the data line and is valid at the first 8 rising edges. Bits 7, 6 and 2..0 are zero. Bits 5..3 hold the channel address, with 000 to 011 meaning inputs 1 to 4.
- R5: Conversion i of a frame addresses list entry i+1, and the last conversion addresses entry 0. Entry j of `chan_list` sits at bits 2j+1..2j.
- R6: The result is taken MSB first at the rising edges of clock cycles 5 through 12 of the conversion. `res_valid` pulses for one system clock, in the same cycle as the 12th rising edge.
- R7: `res_chan` names the address sent in the preceding conversion. The first conversion after reset reports channel 0 (input 1).
- R8: A start whose `half_div` lies outside 16..62 (system clock 100 MHz, serial clock 0.8 to 3.2 MHz) gives a one-cycle `cfg_reject` pulse and no frame.
- R9: A start pulse while a frame is running is ignored. The frame runs on with its latched settings, and no second frame follows.
- R10: Chip select stays low across all conversions of a frame, and the frame gives one result per conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a frame with the current settings |
| conv_last | input | 2 | Number of conversions minus one |
| chan_list | input | 8 | Channel list, 2 bits per entry |
| half_div | input | 8 | System clocks per serial clock half period |
| busy | output | 1 | Frame in progress |
| cfg_reject | output | 1 | Divider out of range, start refused |
| cs_n | output | 1 | Chip select, active low |
| sclk | output | 1 | Serial clock, idles high |
| mosi | output | 1 | Control word to converter |
| miso | input | 1 | Result bits from converter |
| res_valid | output | 1 | Result strobe |
| res_code | output | 8 | Converted code |
| res_chan | output | 2 | Channel the code belongs to |

## Verification
The bench samples on the falling system clock. The reject pulse is due one clock after the start. Busy and a low chip select are due by that same point. The first serial clock edge is due exactly `half_div` clocks after chip select falls, and every later edge a further `half_div` clocks on. The bench measures each of these gaps. The bench's converter model acts on the serial clock edges it sees. It drives data a half period before the controller samples it. It checks each control word once the 8th rising edge has been seen. Each result strobe must appear in the very sample where the 12th rising edge of the conversion is first seen. The code and tag are compared there against values worked out from the list and the last address the bench expects to have been sent.

// File: rtl/adcm_pkg.sv
package adcm_pkg;

    localparam int CODE_W     = 8;
    localparam int CH_W       = 2;
    localparam int CONV_CLKS  = 16;
    localparam int WORD_BITS  = 8;
    localparam int DATA_FIRST = 4;
    localparam int DATA_LAST  = 11;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_TAIL
    } fsm_t;

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic [CH_W-1:0]   chan;
    } result_t;

    // control word: address in bits 5..3, every other bit driven low
    function automatic logic [WORD_BITS-1:0] ctrl_word(input logic [CH_W-1:0] ch);
        return {2'b00, 1'b0, ch, 3'b000};
    endfunction

    function automatic logic div_in_range(input int unsigned d, input int unsigned lo,
                                          input int unsigned hi);
        return (d >= lo) && (d <= hi);
    endfunction

endpackage

// File: rtl/adcm_halfclk.sv
module adcm_halfclk #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;

    assign tick = en && (cnt_q == div - 1'b1);

    always_ff @(posedge clk) begin
        if (rst || !en || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/adcm_serdes.sv
module adcm_serdes
    import adcm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              fall_ev,
    input  logic              rise_ev,
    input  logic [3:0]        cyc,
    input  logic [CH_W-1:0]   addr,
    input  logic              miso,
    output logic              mosi,
    output logic              done,
    output logic [CODE_W-1:0] code
);
    logic [WORD_BITS-1:0] word;
    logic [CODE_W-1:0]    sh_q;
    logic                 in_window;

    assign word      = ctrl_word(addr);
    assign in_window = (cyc >= 4'(DATA_FIRST)) && (cyc <= 4'(DATA_LAST));

    always_ff @(posedge clk) begin
        if (rst) begin
            mosi <= 1'b0;
            sh_q <= '0;
            done <= 1'b0;
            code <= '0;
        end else begin
            done <= 1'b0;
            if (fall_ev) begin
                mosi <= (cyc < 4'(WORD_BITS)) ? word[3'(4'd7 - cyc)] : 1'b0;
            end
            if (rise_ev && in_window) begin
                sh_q <= {sh_q[CODE_W-2:0], miso};
                if (cyc == 4'(DATA_LAST)) begin
                    done <= 1'b1;
                    code <= {sh_q[CODE_W-2:0], miso};
                end
            end
        end
    end
endmodule

// File: rtl/adcm_chan_track.sv
module adcm_chan_track
    import adcm_pkg::*;
#(
    parameter int MAX_CONV = 4,
    parameter int CNT_W    = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [MAX_CONV*CH_W-1:0] list,
    input  logic [CNT_W-1:0]         conv,
    input  logic [CNT_W-1:0]         last,
    input  logic                     conv_end,
    output logic [CH_W-1:0]          next_addr,
    output logic [CH_W-1:0]          tag
);
    logic [CH_W-1:0]  ch_arr [MAX_CONV];
    logic [CNT_W-1:0] nxt_idx;

    for (genvar g = 0; g < MAX_CONV; g++) begin : g_unpack
        assign ch_arr[g] = list[g*CH_W +: CH_W];
    end

    assign nxt_idx   = (conv == last) ? '0 : conv + 1'b1;
    assign next_addr = ch_arr[nxt_idx];

    // converter powers up selecting input 1 (code 0)
    always_ff @(posedge clk) begin
        if (rst) begin
            tag <= '0;
        end else if (conv_end) begin
            tag <= next_addr;
        end
    end
endmodule

// File: rtl/adcm_frame_master.sv
module adcm_frame_master
    import adcm_pkg::*;
#(
    parameter  int SYS_HZ      = 100_000_000,
    parameter  int SCLK_MIN_HZ = 800_000,
    parameter  int SCLK_MAX_HZ = 3_200_000,
    parameter  int MAX_CONV    = 4,
    parameter  int DIV_W       = 8,
    localparam int CNT_W       = (MAX_CONV > 1) ? $clog2(MAX_CONV) : 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     start,
    input  logic [CNT_W-1:0]         conv_last,
    input  logic [MAX_CONV*CH_W-1:0] chan_list,
    input  logic [DIV_W-1:0]         half_div,
    output logic                     busy,
    output logic                     cfg_reject,
    output logic                     cs_n,
    output logic                     sclk,
    output logic                     mosi,
    input  logic                     miso,
    output logic                     res_valid,
    output logic [CODE_W-1:0]        res_code,
    output logic [CH_W-1:0]          res_chan
);
    localparam int DIV_LO = (SYS_HZ + 2*SCLK_MAX_HZ - 1) / (2*SCLK_MAX_HZ);
    localparam int DIV_HI = SYS_HZ / (2*SCLK_MIN_HZ);

    fsm_t                     st_q;
    logic [DIV_W-1:0]         div_q;
    logic [CNT_W-1:0]         last_q;
    logic [CNT_W-1:0]         conv_q;
    logic [MAX_CONV*CH_W-1:0] list_q;
    logic [3:0]               cyc_q;
    logic                     tick;
    logic                     fall_ev;
    logic                     rise_ev;
    logic                     conv_end;
    logic [CH_W-1:0]          next_addr;
    logic [CH_W-1:0]          tag;
    result_t                  res;

    assign busy     = (st_q != ST_IDLE);
    assign fall_ev  = (st_q == ST_RUN) && tick && sclk;
    assign rise_ev  = (st_q == ST_RUN) && tick && !sclk;
    assign conv_end = rise_ev && (cyc_q == 4'(CONV_CLKS - 1));

    adcm_halfclk #(.DIV_W(DIV_W)) u_halfclk (
        .clk  (clk),
        .rst  (rst),
        .en   (busy),
        .div  (div_q),
        .tick (tick)
    );

    adcm_chan_track #(.MAX_CONV(MAX_CONV), .CNT_W(CNT_W)) u_track (
        .clk       (clk),
        .rst       (rst),
        .list      (list_q),
        .conv      (conv_q),
        .last      (last_q),
        .conv_end  (conv_end),
        .next_addr (next_addr),
        .tag       (tag)
    );

    adcm_serdes u_serdes (
        .clk     (clk),
        .rst     (rst),
        .fall_ev (fall_ev),
        .rise_ev (rise_ev),
        .cyc     (cyc_q),
        .addr    (next_addr),
        .miso    (miso),
        .mosi    (mosi),
        .done    (res_valid),
        .code    (res.code)
    );

    assign res.chan = tag;
    assign res_code = res.code;
    assign res_chan = res.chan;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= ST_IDLE;
            cs_n       <= 1'b1;
            sclk       <= 1'b1;
            cfg_reject <= 1'b0;
            div_q      <= DIV_W'(DIV_LO);
            last_q     <= '0;
            conv_q     <= '0;
            list_q     <= '0;
            cyc_q      <= '0;
        end else begin
            cfg_reject <= 1'b0;
            unique case (st_q)
                ST_IDLE: begin
                    if (start) begin
                        if (div_in_range(int'(half_div), DIV_LO, DIV_HI)) begin
                            div_q  <= half_div;
                            last_q <= conv_last;
                            list_q <= chan_list;
                            conv_q <= '0;
                            cyc_q  <= '0;
                            cs_n   <= 1'b0;
                            st_q   <= ST_RUN;
                        end else begin
                            cfg_reject <= 1'b1;
                        end
                    end
                end
                ST_RUN: begin
                    if (tick) begin
                        if (sclk) begin
                            sclk <= 1'b0;
                        end else begin
                            sclk <= 1'b1;
                            if (cyc_q == 4'(CONV_CLKS - 1)) begin
                                cyc_q <= '0;
                                if (conv_q == last_q) begin
                                    st_q <= ST_TAIL;
                                end else begin
                                    conv_q <= conv_q + 1'b1;
                                end
                            end else begin
                                cyc_q <= cyc_q + 1'b1;
                            end
                        end
                    end
                end
                ST_TAIL: begin
                    if (tick) begin
                        cs_n <= 1'b1;
                        st_q <= ST_IDLE;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/adcm_frame_master_chk.sv
module adcm_frame_master_chk #(
    parameter int DIV_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             busy,
    input logic             cfg_reject,
    input logic             cs_n,
    input logic             sclk,
    input logic             res_valid,
    input logic [DIV_W-1:0] div_q
);
    logic           cs_prev;
    logic           sclk_prev;
    logic [DIV_W:0] gap;

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_prev   <= 1'b1;
            sclk_prev <= 1'b1;
            gap       <= '0;
        end else begin
            cs_prev   <= cs_n;
            sclk_prev <= sclk;
            if ((cs_prev && !cs_n) || (sclk != sclk_prev)) begin
                gap <= 1;
            end else begin
                gap <= gap + 1'b1;
            end
        end
    end

    a_r1_idle_lines_high: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (cs_n && sclk));

    a_r2_cs_fall_clock_high: assert property (@(posedge clk) disable iff (rst)
        $fell(cs_n) |-> sclk);

    a_r2_cs_rise_clock_high: assert property (@(posedge clk) disable iff (rst)
        $rose(cs_n) |-> sclk);

    a_r3_half_period: assert property (@(posedge clk) disable iff (rst)
        (sclk != $past(sclk)) |-> (gap == {1'b0, div_q}));

    a_r6_valid_on_rise: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> $rose(sclk));

    a_r8_reject_no_frame: assert property (@(posedge clk) disable iff (rst)
        cfg_reject |-> (cs_n && !busy));
endmodule

bind adcm_frame_master adcm_frame_master_chk #(.DIV_W(DIV_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .busy       (busy),
    .cfg_reject (cfg_reject),
    .cs_n       (cs_n),
    .sclk       (sclk),
    .res_valid  (res_valid),
    .div_q      (div_q)
);

// File: tb/adcm_frame_master_test.sv
module adcm_frame_master_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [1:0] conv_last = '0;
    logic [7:0] chan_list = '0;
    logic [7:0] half_div = 8'd16;
    logic       miso = 1'b0;
    logic       busy, cfg_reject, cs_n, sclk, mosi, res_valid;
    logic [7:0] res_code;
    logic [1:0] res_chan;

    always #5 clk = ~clk;

    adcm_frame_master uut (
        .clk(clk), .rst(rst), .start(start), .conv_last(conv_last),
        .chan_list(chan_list), .half_div(half_div), .busy(busy),
        .cfg_reject(cfg_reject), .cs_n(cs_n), .sclk(sclk), .mosi(mosi),
        .miso(miso), .res_valid(res_valid), .res_code(res_code), .res_chan(res_chan)
    );

    int total = 0;
    int bad = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] mval(input int ch, input int k);
        return 8'((ch * 61 + k * 13 + 3) & 255);
    endfunction

    // expectations and converter model state
    int         f_div = 16;
    int         exp_tag [4];
    int         exp_nxt [4];
    int         pend = 0;
    bit         prev_cs = 1'b1;
    bit         prev_sclk = 1'b1;
    int         gap = 0;
    int         lead = 0;
    bit         first_tog = 1'b0;
    int         rises = 0;
    int         ri = 0;
    int         fi = 0;
    int         half_bad = 0;
    int         edge_bad = 0;
    int         n_res = 0;
    int         kconv = 0;
    int         sel = 0;
    logic [7:0] word = '0;
    logic [7:0] mcode = '0;
    bit         frame_done = 1'b0;

    always @(negedge clk) begin
        if (!rst) begin
            bit rose_now;
            rose_now = 1'b0;
            if (prev_cs && !cs_n) begin
                gap = 0; first_tog = 1'b1; rises = 0; ri = 0; fi = 0;
                if (!sclk) edge_bad++;
            end else begin
                gap++;
            end
            if (!cs_n && (sclk != prev_sclk)) begin
                if (first_tog) lead = gap;
                else if (gap != f_div) half_bad++;
                first_tog = 1'b0;
                gap = 0;
                if (!sclk) begin
                    int lf;
                    lf = fi % 16;
                    if (lf == 0) mcode = mval(sel, kconv);
                    miso = (lf >= 4 && lf <= 11) ? mcode[11 - lf] : 1'b0;
                    fi++;
                end else begin
                    int lr;
                    rose_now = 1'b1;
                    lr = ri % 16;
                    if (lr < 8) word = {word[6:0], mosi};
                    if (lr == 7) begin
                        chk((word & 8'hC7) == 8'h00, "R4 unused control bits zero", int'(word), int'(word & 8'h38));
                        chk(int'(word[5:3]) == exp_nxt[(ri / 16) % 4], "R5 address of next conversion",
                            int'(word[5:3]), exp_nxt[(ri / 16) % 4]);
                    end
                    if (lr == 15) begin
                        sel = int'(word[5:3]);
                        kconv++;
                    end
                    ri++;
                    rises++;
                end
            end
            if (res_valid) begin
                chk(rose_now && (ri % 16 == 12), "R6 strobe at 12th rising edge", ri % 16, 12);
                if (n_res < 4) begin
                    chk(int'(res_chan) == exp_tag[n_res], "R7 result channel tag", int'(res_chan), exp_tag[n_res]);
                    chk(res_code == mval(exp_tag[n_res], kconv), "R6 result code", int'(res_code),
                        int'(mval(exp_tag[n_res], kconv)));
                end
                n_res++;
            end
            if (!prev_cs && cs_n) begin
                if (!sclk) edge_bad++;
                miso = 1'b0;
                frame_done = 1'b1;
            end
            prev_cs = cs_n;
            prev_sclk = sclk;
        end
    end

    task automatic run_frame(input int n, input logic [7:0] lst, input int div, input bit poke);
        int t;
        int viol;
        for (int i = 0; i < n; i++) begin
            exp_tag[i] = (i == 0) ? pend : int'(lst[2*i +: 2]);
            exp_nxt[i] = int'(lst[2*((i + 1) % n) +: 2]);
        end
        n_res = 0; half_bad = 0; edge_bad = 0; frame_done = 1'b0;
        @(negedge clk);
        chan_list = lst; conv_last = 2'(n - 1); half_div = 8'(div); f_div = div; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy && !cs_n, "R2 frame opens one clock after start", int'(cs_n), 0);
        if (poke) begin
            repeat (100) @(negedge clk);
            chan_list = ~lst; conv_last = 2'd0; half_div = 8'd62; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        t = 0;
        while (!frame_done && t < 20000) begin
            @(negedge clk);
            t++;
        end
        chk(frame_done, "R2 frame closes", int'(frame_done), 1);
        chk(rises == 16 * n, "R2 rising edges per frame", rises, 16 * n);
        chk(n_res == n, "R10 one result per conversion in one frame", n_res, n);
        chk(lead == div, "R3 lead from chip select to first edge", lead, div);
        chk(half_bad == 0, "R3 half periods match divider", half_bad, 0);
        chk(edge_bad == 0, "R2 clock high at chip select edges", edge_bad, 0);
        pend = int'(lst[1:0]);
        viol = 0;
        repeat (poke ? 200 : 4) begin
            @(negedge clk);
            if (!cs_n || busy) viol++;
        end
        chk(viol == 0, poke ? "R9 start during frame ignored" : "R10 idle after frame", viol, 0);
    endtask

    task automatic reject(input int div);
        int viol;
        @(negedge clk);
        half_div = 8'(div); chan_list = 8'hE4; conv_last = 2'd3; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(cfg_reject == 1'b1, "R8 reject pulse", int'(cfg_reject), 1);
        viol = 0;
        repeat (50) begin
            @(negedge clk);
            if (!cs_n || busy || cfg_reject) viol++;
        end
        chk(viol == 0, "R8 no frame after reject", viol, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 190000, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(cs_n && sclk, "R1 chip select and clock high after reset", int'({cs_n, sclk}), 3);
        chk(!busy && !cfg_reject && !res_valid && !mosi, "R1 status low after reset",
            int'({busy, cfg_reject, res_valid, mosi}), 0);
        // R8: dividers just outside and far outside the legal window
        reject(15);
        reject(63);
        reject(0);
        // sweep: conversion counts 1..4, four channel patterns, fastest legal clock
        for (int n = 1; n <= 4; n++) begin
            for (int p = 0; p < 4; p++) begin
                logic [7:0] lst;
                for (int i = 0; i < 4; i++) lst[2*i +: 2] = 2'((p * 3 + i * (1 + p)) & 3);
                run_frame(n, lst, 16, 1'b0);
            end
        end
        // slowest legal clock, full list
        run_frame(4, 8'b00_01_10_11, 62, 1'b0);
        // R9: start pulse in the middle of a frame
        run_frame(3, 8'b00_10_01_11, 20, 1'b1);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule